// File: doc/BRIEF.md
# Eight-Function Nibble ALU

This block performs one of eight operations on two 4-bit operands, A and B, and picks the operation with a 3-bit code. It provides unsigned addition and subtraction with a carry/borrow flag. It also provides four bitwise logic functions and logical shifts of A by a distance taken from B. The operands and the code are sampled on a rising clock edge, and the 4-bit result and the flag come from registers. The arithmetic, logic and shift paths are computed side by side, and the registered result is taken from the path the code selects.

A synchronous active-high reset clears both registered outputs. The operand width is a parameter. The default is 4, and the shifter adjusts its stage count to the width.

Top module: `nibble_alu`

## Requirements
- R1: The operation code selects the function as follows: 3'b000 add, 3'b001 and, 3'b010 xor, 3'b011 or, 3'b100 nor, 3'b101 subtract, 3'b110 shift right logical, 3'b111 shift left logical.
- R2: Add (3'b000) gives `r_o` = (A + B) mod 16, and `cout_o` = 1 exactly when A + B > 15.
- R3: Subtract (3'b101) gives `r_o` = (A − B) mod 16, and `cout_o` = 1 exactly when A < B, which marks a borrow.
- R4: For every code other than 3'b000 and 3'b101, `cout_o` is 0 whatever the operands are.
- R5: The and (3'b001), xor (3'b010) and or (3'b011) functions work on each bit position on its own.
- R6: Nor (3'b100) gives the bitwise complement of A or B.
- R7: Shift right (3'b110) moves A toward bit 0 by B positions. Zeros enter at bit 3, bits that pass bit 0 are lost, and nothing rotates.
- R8: Shift left (3'b111) moves A toward bit 3 by B positions. Zeros enter at bit 0, bits that pass bit 3 are lost, and nothing rotates.
- R9: A shift distance B of 4 or more gives `r_o` = 4'b0000 in either direction.
- R10: The outputs are registered. Inputs sampled at a rising edge appear on `r_o` and `cout_o` just after that edge, and the outputs do not change between edges.
- R11: While `rst` is high at a rising edge, both outputs become 0. This holds whatever operands and code are present in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 4 | Operand A; the value that is shifted |
| b_i | input | 4 | Operand B; the shift distance for the shift codes |
| op_i | input | 3 | Operation code |
| r_o | output | 4 | Registered result |
| cout_o | output | 1 | Registered carry (add) or borrow (subtract) flag |

## Verification
Two events can fall in the same edge: a reset, and the capture of a fresh operation that would set the flag and a nonzero result. The bench holds reset high while it applies add 1111 + 1111, whose result would otherwise be 1110 with the flag set. It then checks that both outputs are zero after that edge. Next it releases reset with the same inputs still applied, checks that the full result appears exactly one edge later, and checks that changing the inputs between edges leaves the outputs untouched.

// File: rtl/nibble_alu_pkg.sv
package nibble_alu_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_AND = 3'b001,
    OP_XOR = 3'b010,
    OP_OR  = 3'b011,
    OP_NOR = 3'b100,
    OP_SUB = 3'b101,
    OP_SHR = 3'b110,
    OP_SHL = 3'b111
  } alu_op_e;

endpackage

// File: rtl/nalu_addsub.sv
module nalu_addsub #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic [WIDTH-1:0] diff_o,
  output logic             borrow_o
);

  logic [WIDTH:0] sum_x;
  logic [WIDTH:0] diff_x;

  always_comb begin
    sum_x  = {1'b0, a_i} + {1'b0, b_i};
    diff_x = {1'b0, a_i} - {1'b0, b_i};
  end

  assign sum_o    = sum_x[WIDTH-1:0];
  assign carry_o  = sum_x[WIDTH];
  assign diff_o   = diff_x[WIDTH-1:0];
  assign borrow_o = diff_x[WIDTH];

endmodule

// File: rtl/nalu_bitwise.sv
module nalu_bitwise #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] nor_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
    assign xor_o[i] = a_i[i] ^ b_i[i];
    assign nor_o[i] = ~(a_i[i] | b_i[i]);
  end

endmodule

// File: rtl/nalu_barrel.sv
module nalu_barrel #(
  parameter int WIDTH = 4,
  parameter bit LEFT  = 1'b0
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] dist_i,
  output logic [WIDTH-1:0] data_o
);

  localparam int STAGES = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] stg [STAGES+1];
  logic             too_far;

  assign stg[0] = data_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int STEP = 1 << s;
    if (LEFT) begin : g_l
      assign stg[s+1] = dist_i[s] ? (stg[s] << STEP) : stg[s];
    end else begin : g_r
      assign stg[s+1] = dist_i[s] ? (stg[s] >> STEP) : stg[s];
    end
  end

  if (STAGES < WIDTH) begin : g_range
    assign too_far = |dist_i[WIDTH-1:STAGES];
  end else begin : g_norange
    assign too_far = 1'b0;
  end

  assign data_o = too_far ? '0 : stg[STAGES];

endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
  import nibble_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] r_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] sum_w, diff_w, and_w, or_w, xor_w, nor_w, shr_w, shl_w;
  logic             carry_w, borrow_w;
  logic [WIDTH-1:0] res_d;
  logic             cout_d;

  nalu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(a_i), .b_i(b_i),
    .sum_o(sum_w), .carry_o(carry_w),
    .diff_o(diff_w), .borrow_o(borrow_w)
  );

  nalu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i(a_i), .b_i(b_i),
    .and_o(and_w), .or_o(or_w), .xor_o(xor_w), .nor_o(nor_w)
  );

  nalu_barrel #(.WIDTH(WIDTH), .LEFT(1'b0)) u_shr (
    .data_i(a_i), .dist_i(b_i), .data_o(shr_w)
  );

  nalu_barrel #(.WIDTH(WIDTH), .LEFT(1'b1)) u_shl (
    .data_i(a_i), .dist_i(b_i), .data_o(shl_w)
  );

  always_comb begin
    res_d  = '0;
    cout_d = 1'b0;
    case (alu_op_e'(op_i))
      OP_ADD: begin res_d = sum_w;  cout_d = carry_w;  end
      OP_AND: res_d = and_w;
      OP_XOR: res_d = xor_w;
      OP_OR:  res_d = or_w;
      OP_NOR: res_d = nor_w;
      OP_SUB: begin res_d = diff_w; cout_d = borrow_w; end
      OP_SHR: res_d = shr_w;
      OP_SHL: res_d = shl_w;
      default: begin res_d = '0; cout_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_o    <= '0;
      cout_o <= 1'b0;
    end else begin
      r_o    <= res_d;
      cout_o <= cout_d;
    end
  end

  // R11
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (r_o == '0 && cout_o == 1'b0));

  // R4
  no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) != OP_ADD && $past(op_i) != OP_SUB) |-> (cout_o == 1'b0));

  // R2
  add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_ADD) |->
      ({cout_o, r_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

  // R3
  sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_SUB) |-> (cout_o == ($past(a_i) < $past(b_i))));

  // R9
  shift_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_SHR || $past(op_i) == OP_SHL)
      && $past(b_i) >= WIDTH) |-> (r_o == '0));

endmodule

// File: tb/nibble_alu_bench.sv
module nibble_alu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;
  // packed vector: {op[2:0], a[3:0], b[3:0], r[3:0], cout}
  localparam logic [15:0] VEC [NVEC] = '{
    {3'b000, 4'h2, 4'h4, 4'h6, 1'b0},
    {3'b000, 4'hC, 4'h8, 4'h4, 1'b1},
    {3'b000, 4'hF, 4'h2, 4'h1, 1'b1},
    {3'b000, 4'h9, 4'h7, 4'h0, 1'b1},
    {3'b001, 4'h2, 4'h3, 4'h2, 1'b0},
    {3'b010, 4'h2, 4'h3, 4'h1, 1'b0},
    {3'b011, 4'h2, 4'h3, 4'h3, 1'b0},
    {3'b100, 4'h2, 4'h3, 4'hC, 1'b0},
    {3'b101, 4'h2, 4'h3, 4'hF, 1'b1},
    {3'b101, 4'h4, 4'h1, 4'h3, 1'b0},
    {3'b101, 4'h9, 4'h7, 4'h2, 1'b0},
    {3'b101, 4'hF, 4'h2, 4'hD, 1'b0},
    {3'b110, 4'hC, 4'h2, 4'h3, 1'b0},
    {3'b110, 4'h3, 4'h1, 4'h1, 1'b0},
    {3'b110, 4'h3, 4'h2, 4'h0, 1'b0},
    {3'b111, 4'hC, 4'h2, 4'h0, 1'b0},
    {3'b111, 4'h3, 4'h3, 4'h8, 1'b0},
    {3'b111, 4'hF, 4'h4, 4'h0, 1'b0},
    {3'b110, 4'hF, 4'hF, 4'h0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a = '0, b = '0;
  logic [2:0] op = '0;
  logic [3:0] r;
  logic       cout;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_alu #(.WIDTH(4)) u_nibble_alu (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .op_i(op), .r_o(r), .cout_o(cout)
  );

  function automatic logic [4:0] model(logic [2:0] o, logic [3:0] x, logic [3:0] y);
    logic [4:0] t;
    case (o)
      3'b000: t = {1'b0, x} + {1'b0, y};
      3'b001: t = {1'b0, x & y};
      3'b010: t = {1'b0, x ^ y};
      3'b011: t = {1'b0, x | y};
      3'b100: t = {1'b0, ~(x | y)};
      3'b101: t = {(x < y), 4'(x - y)};
      3'b110: t = {1'b0, (y > 4'd3) ? 4'h0 : (x >> y)};
      default: t = {1'b0, (y > 4'd3) ? 4'h0 : (x << y)};
    endcase
    return t;
  endfunction

  function automatic string tag_of(logic [2:0] o, logic [3:0] y);
    case (o)
      3'b000: return "R2";
      3'b101: return "R3";
      3'b100: return "R6 R4";
      3'b110: return (y > 4'd3) ? "R9 R4" : "R7 R4";
      3'b111: return (y > 4'd3) ? "R9 R4" : "R8 R4";
      default: return "R5 R4";
    endcase
  endfunction

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual cout=%b r=%h expected cout=%b r=%h",
               tag, got[4], got[3:0], exp[4], exp[3:0]);
    end
  endtask

  task automatic run_op(logic [2:0] o, logic [3:0] x, logic [3:0] y);
    a = x; b = y; op = o;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R11 reset state", {cout, r}, 5'b0);
    rst = 1'b0;

    // table of directed vectors
    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][15:13], VEC[i][12:9], VEC[i][8:5]);
      check($sformatf("%s R1 vec%0d", tag_of(VEC[i][15:13], VEC[i][8:5]), i),
            {cout, r}, {VEC[i][0], VEC[i][4:1]});
    end

    // every code over every operand pair
    for (int o = 0; o < 8; o++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          run_op(3'(o), 4'(x), 4'(y));
          check($sformatf("%s R1 op=%0d a=%0d b=%0d", tag_of(3'(o), 4'(y)), o, x, y),
                {cout, r}, model(3'(o), 4'(x), 4'(y)));
        end

    // R10: outputs hold between edges, then update one edge later
    run_op(3'b000, 4'h1, 4'h1);
    a = 4'hF; b = 4'hF; op = 3'b101;
    #1;
    check("R10 hold between edges", {cout, r}, 5'b0_0010);
    @(posedge clk); @(negedge clk);
    check("R10 update after edge", {cout, r}, 5'b0_0000);

    // R11: reset in the same cycle as a flag-setting add
    rst = 1'b1;
    run_op(3'b000, 4'hF, 4'hF);
    check("R11 reset beats add", {cout, r}, 5'b0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11 release then R2 add", {cout, r}, 5'b1_1110);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule